// File: doc/BRIEF.md
# Single-Register Shift and Rotate Unit

This unit is the shift/rotate execution stage of a 64-bit register-file processor. Each cycle it takes an operation code, a width select, a source register value, the current destination value and the operands of a base-plus-displacement shift amount. It produces the new destination value and, for the two arithmetic operations, a condition code. The result is registered, so it appears one clock after the operands.

Five operations are supported, each in a 32-bit and a 64-bit form: logical left shift, logical right shift, arithmetic right shift, sign-preserving arithmetic left shift with overflow detection, and left rotate. A 32-bit form works on the low word of the source and writes only the low word of the destination; the high word is taken from the old destination value. The unit has no state machine: its only state is the output register, loaded on every clock.

Top module: `shr_unit`

## Requirements
- R1: The shift amount is `disp` when `base_en` is 0 and `base_val + disp` when `base_en` is 1. It is then masked to its low 6 bits when `wide`=1 (64-bit form) or its low 5 bits when `wide`=0 (32-bit form). An amount equal to the width therefore acts as zero.
- R2: `op_sel`=0 shifts the operand left and fills with zeros. `op_sel`=1 shifts it right and fills with zeros. Both drive `cc_valid` low and `cc` to 0.
- R3: `op_sel`=3 (arithmetic left) shifts left, but the result's top bit (bit 63, or bit 31 in the 32-bit form) is the source's top bit. If any bit shifted into or past the top bit differs from the source's top bit, `cc` is 3 and `cc_valid` is 1.
- R4: For `op_sel`=3 without overflow, `cc` is 0 for a zero result, 1 for a negative result and 2 for a positive one. An amount of 0 never overflows and passes the operand through unchanged.
- R5: `op_sel`=2 shifts right and fills with the operand's sign bit. `cc` takes 0, 1 or 2 from the signed result, never 3, and `cc_valid` is 1.
- R6: `op_sel`=4 rotates the operand left. Bits leaving the top re-enter at bit 0. `cc_valid` is low.
- R7: When `wide`=0, the operation uses only `src_val[31:0]`: sign-extended for op 2, zero-extended for op 1, rotated within 32 bits for op 4. The result goes to `dst_new[31:0]`, and `dst_new[63:32]` equals `dst_old[63:32]`.
- R8: Outputs are registered and reflect the inputs present at the previous rising clock edge. While `rst_n` is low, `dst_new`, `cc_valid` and `cc` are all zero.
- R9: `op_sel` values 5 to 7 are reserved. They give `dst_new` = `dst_old`, `cc_valid` = 0 and `cc` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_sel | input | 3 | Operation: 0 shl, 1 shr, 2 asr, 3 asl, 4 rol, 5-7 reserved |
| wide | input | 1 | 1 selects the 64-bit form, 0 the 32-bit form |
| src_val | input | 64 | Operand to shift or rotate |
| dst_old | input | 64 | Current destination value |
| base_en | input | 1 | Base register present |
| base_val | input | 64 | Base register value |
| disp | input | 20 | Displacement |
| dst_new | output | 64 | New destination value |
| cc_valid | output | 1 | Condition code is produced by this operation |
| cc | output | 2 | Condition code |

## Verification
Every result (`dst_new`, `cc_valid`, `cc`) is due exactly one rising edge after its operands are applied, because a single register stage sits between the inputs and the outputs. The bench applies a new operand set on each falling edge. It pushes the reference result onto a queue and pops and compares it at the following falling edge, so each comparison lands half a period after the register loads it. The bound assertions use the same one-cycle relation through `$past`. They are gated by a flag that becomes true one edge after reset is released.

// File: rtl/shr_pkg.sv
package shr_pkg;

    typedef enum logic [2:0] {
        OPC_SHL = 3'd0,
        OPC_SHR = 3'd1,
        OPC_ASR = 3'd2,
        OPC_ASL = 3'd3,
        OPC_ROL = 3'd4
    } shr_op_e;

    localparam logic [1:0] CC_ZERO = 2'd0;
    localparam logic [1:0] CC_NEG  = 2'd1;
    localparam logic [1:0] CC_POS  = 2'd2;
    localparam logic [1:0] CC_OVF  = 2'd3;

endpackage

// File: rtl/shr_amount.sv
module shr_amount #(
    parameter int XLEN   = 64,
    parameter int DISP_W = 20,
    localparam int AW    = $clog2(XLEN)
) (
    input  logic              wide,
    input  logic              base_en,
    input  logic [XLEN-1:0]   base_val,
    input  logic [DISP_W-1:0] disp,
    output logic [AW-1:0]     amt
);
    // Only the low AW bits of the sum survive the mask, so only those are added.
    logic [AW-1:0] base_lo;
    logic [AW-1:0] sum_lo;
    logic          unused_hi;

    assign base_lo   = base_en ? base_val[AW-1:0] : '0;
    assign sum_lo    = base_lo + disp[AW-1:0];
    assign amt       = wide ? sum_lo : {1'b0, sum_lo[AW-2:0]};
    assign unused_hi = ^{base_val[XLEN-1:AW], disp[DISP_W-1:AW]};

endmodule

// File: rtl/shr_lane.sv
module shr_lane
    import shr_pkg::*;
#(
    parameter int W   = 64,
    localparam int AW = $clog2(W)
) (
    input  shr_op_e       op,
    input  logic [W-1:0]  src,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  res,
    output logic          ccv,
    output logic [1:0]    cc
);
    logic [2*W-1:0] dbl;
    logic [W-1:0]   shl_v, shr_v, asr_v, asl_v, rol_v;
    logic           ovf;

    always_comb begin
        dbl   = {src, src} << amt;
        rol_v = dbl[2*W-1:W];
        shl_v = src << amt;
        shr_v = src >> amt;
        asr_v = $signed(src) >>> amt;
        asl_v = {src[W-1], shl_v[W-2:0]};
        // Bit i reaches or crosses the sign position when i + amt >= W-1.
        ovf = 1'b0;
        for (int i = 0; i < W - 1; i++) begin
            if ((i + int'(amt)) >= (W - 1) && (src[i] != src[W-1])) begin
                ovf = 1'b1;
            end
        end
    end

    always_comb begin
        res = '0;
        ccv = 1'b0;
        cc  = CC_ZERO;
        unique case (op)
            OPC_SHL: res = shl_v;
            OPC_SHR: res = shr_v;
            OPC_ROL: res = rol_v;
            OPC_ASR: begin
                res = asr_v;
                ccv = 1'b1;
                if (asr_v == '0)      cc = CC_ZERO;
                else if (asr_v[W-1])  cc = CC_NEG;
                else                  cc = CC_POS;
            end
            OPC_ASL: begin
                res = asl_v;
                ccv = 1'b1;
                if (ovf)              cc = CC_OVF;
                else if (asl_v == '0) cc = CC_ZERO;
                else if (asl_v[W-1])  cc = CC_NEG;
                else                  cc = CC_POS;
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/shr_unit.sv
module shr_unit
    import shr_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int DISP_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_sel,
    input  logic              wide,
    input  logic [XLEN-1:0]   src_val,
    input  logic [XLEN-1:0]   dst_old,
    input  logic              base_en,
    input  logic [XLEN-1:0]   base_val,
    input  logic [DISP_W-1:0] disp,
    output logic [XLEN-1:0]   dst_new,
    output logic              cc_valid,
    output logic [1:0]        cc
);
    localparam int HALF = XLEN / 2;
    localparam int AW   = $clog2(XLEN);

    logic [AW-1:0]   amt;
    shr_op_e         op_e;
    logic [XLEN-1:0] nxt_dst;
    logic            nxt_ccv;
    logic [1:0]      nxt_cc;

    assign op_e = shr_op_e'(op_sel);

    shr_amount #(.XLEN(XLEN), .DISP_W(DISP_W)) u_amt (
        .wide     (wide),
        .base_en  (base_en),
        .base_val (base_val),
        .disp     (disp),
        .amt      (amt)
    );

    // Lane 0 is the 32-bit form, lane 1 the full-width form.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int LW = (g == 0) ? HALF : XLEN;
        logic [LW-1:0] res_w;
        logic          ccv_w;
        logic [1:0]    cc_w;
        shr_lane #(.W(LW)) u_lane (
            .op  (op_e),
            .src (src_val[LW-1:0]),
            .amt (amt[$clog2(LW)-1:0]),
            .res (res_w),
            .ccv (ccv_w),
            .cc  (cc_w)
        );
    end

    always_comb begin
        if (op_sel > 3'd4) begin
            nxt_dst = dst_old;
            nxt_ccv = 1'b0;
            nxt_cc  = CC_ZERO;
        end else if (wide) begin
            nxt_dst = g_lane[1].res_w;
            nxt_ccv = g_lane[1].ccv_w;
            nxt_cc  = g_lane[1].cc_w;
        end else begin
            nxt_dst = {dst_old[XLEN-1:HALF], g_lane[0].res_w};
            nxt_ccv = g_lane[0].ccv_w;
            nxt_cc  = g_lane[0].cc_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_new  <= '0;
            cc_valid <= 1'b0;
            cc       <= CC_ZERO;
        end else begin
            dst_new  <= nxt_dst;
            cc_valid <= nxt_ccv;
            cc       <= nxt_cc;
        end
    end

endmodule

// File: rtl/shr_unit_chk.sv
module shr_unit_chk
    import shr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      op_sel,
    input logic            wide,
    input logic [XLEN-1:0] src_val,
    input logic [XLEN-1:0] dst_old,
    input logic [XLEN-1:0] dst_new,
    input logic            cc_valid,
    input logic [1:0]      cc
);
    localparam int HALF = XLEN / 2;

    logic warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm <= 1'b0;
        else        warm <= 1'b1;
    end

    p_no_cc_logic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        warm && ($past(op_sel) == OPC_SHL || $past(op_sel) == OPC_SHR)
        |-> !cc_valid);

    p_no_cc_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $past(op_sel) == OPC_ROL |-> !cc_valid);

    p_sign_kept64_r3: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $past(op_sel) == OPC_ASL && $past(wide)
        |-> dst_new[XLEN-1] == $past(src_val[XLEN-1]));

    p_sign_kept32_r3: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $past(op_sel) == OPC_ASL && !$past(wide)
        |-> dst_new[HALF-1] == $past(src_val[HALF-1]));

    p_asr_no_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $past(op_sel) == OPC_ASR |-> cc_valid && cc != CC_OVF);

    p_keep_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        warm && !$past(wide) && $past(op_sel) <= 3'd4
        |-> dst_new[XLEN-1:HALF] == $past(dst_old[XLEN-1:HALF]));

    p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $past(op_sel) > 3'd4
        |-> dst_new == $past(dst_old) && !cc_valid && cc == CC_ZERO);

endmodule

bind shr_unit shr_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_sel   (op_sel),
    .wide     (wide),
    .src_val  (src_val),
    .dst_old  (dst_old),
    .dst_new  (dst_new),
    .cc_valid (cc_valid),
    .cc       (cc)
);

// File: tb/shr_unit_tb.sv
`timescale 1ns/1ps
module shr_unit_tb;
    localparam int XLEN   = 64;
    localparam int DISP_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        op_sel = '0;
    logic              wide = 1'b0;
    logic [XLEN-1:0]   src_val = '0;
    logic [XLEN-1:0]   dst_old = '0;
    logic              base_en = 1'b0;
    logic [XLEN-1:0]   base_val = '0;
    logic [DISP_W-1:0] disp = '0;
    logic [XLEN-1:0]   dst_new;
    logic              cc_valid;
    logic [1:0]        cc;

    typedef struct {
        logic [63:0] d;
        logic        v;
        logic [1:0]  c;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    always #2.5 clk = ~clk;

    shr_unit #(.XLEN(XLEN), .DISP_W(DISP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .wide(wide),
        .src_val(src_val), .dst_old(dst_old), .base_en(base_en),
        .base_val(base_val), .disp(disp), .dst_new(dst_new),
        .cc_valid(cc_valid), .cc(cc)
    );

    // Bit-serial reference: one position per loop pass.
    function automatic void model(input logic [2:0] op, input logic wd,
                                  input logic [63:0] s, input logic [63:0] dold,
                                  input logic be, input logic [63:0] b,
                                  input logic [19:0] dp, output logic [63:0] r,
                                  output logic v, output logic [1:0] c);
        logic [63:0] t, a, m;
        logic        sg, ov;
        int          w, n;
        w  = wd ? 64 : 32;
        t  = (be ? b : 64'd0) + {44'd0, dp};
        n  = wd ? int'(t[5:0]) : int'(t[4:0]);
        a  = wd ? s : {32'd0, s[31:0]};
        m  = wd ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        sg = a[w-1];
        ov = 1'b0;
        v  = 1'b0;
        c  = 2'd0;
        if (op > 3'd4) begin
            r = dold;
            return;
        end
        for (int k = 0; k < n; k++) begin
            case (op)
                3'd0: a = (a << 1) & m;
                3'd1: a = a >> 1;
                3'd2: begin a = a >> 1; a[w-1] = sg; end
                3'd3: begin
                    if (a[w-2] != sg) ov = 1'b1;
                    a = (a << 1) & m;
                    a[w-1] = sg;
                end
                default: a = ((a << 1) & m) | {63'd0, a[w-1]};
            endcase
        end
        if (op == 3'd2 || op == 3'd3) begin
            v = 1'b1;
            if (op == 3'd3 && ov) c = 2'd3;
            else if (a == 64'd0)  c = 2'd0;
            else if (a[w-1])      c = 2'd1;
            else                  c = 2'd2;
        end
        r = wd ? a : {dold[63:32], a[31:0]};
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic wd);
        string t;
        case (op)
            3'd0, 3'd1: t = "R2";
            3'd2:       t = "R5";
            3'd3:       t = "R3/R4";
            3'd4:       t = "R6";
            default:    t = "R9";
        endcase
        if (!wd && op <= 3'd4) t = {t, "+R7"};
        return t;
    endfunction

    task automatic compare_head();
        exp_t e;
        if (q.size() == 0) return;
        e = q.pop_front();
        n_chk++;
        if (dst_new !== e.d || cc_valid !== e.v || cc !== e.c) begin
            n_fail++;
            $display("FAIL %s: dst=%h ccv=%b cc=%0d expected dst=%h ccv=%b cc=%0d",
                     e.tag, dst_new, cc_valid, cc, e.d, e.v, e.c);
        end
    endtask

    // At each falling edge: check the result of the previous vector, then drive the next one.
    task automatic step(input logic [2:0] op, input logic wd, input logic [63:0] s,
                        input logic [63:0] dold, input logic be, input logic [63:0] b,
                        input logic [19:0] dp, input string tag);
        exp_t e;
        @(negedge clk);
        compare_head();
        op_sel = op; wide = wd; src_val = s; dst_old = dold;
        base_en = be; base_val = b; disp = dp;
        model(op, wd, s, dold, be, b, dp, e.d, e.v, e.c);
        e.tag = tag;
        q.push_back(e);
    endtask

    localparam logic [63:0] HI = 64'hA5A5_5A5A_0000_0000;

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        n_chk++;
        if (dst_new !== 64'd0 || cc_valid !== 1'b0 || cc !== 2'd0) begin
            n_fail++;
            $display("FAIL R8: dst=%h ccv=%b cc=%0d expected dst=0 ccv=0 cc=0",
                     dst_new, cc_valid, cc);
        end
        rst_n = 1'b1;
        // R1: base plus displacement, masked
        step(3'd0, 1'b1, 64'd1, HI, 1'b1, 64'h3F, 20'd2, "R1");
        step(3'd0, 1'b0, 64'd1, HI, 1'b0, 64'hFFFF, 20'h25, "R1");
        step(3'd0, 1'b1, 64'h1234, HI, 1'b0, 64'd0, 20'd64, "R1 amount=width");
        step(3'd1, 1'b0, 64'hDEAD_0000_0000_00F0, HI, 1'b1, 64'd30, 20'd2, "R1 amount=width");
        // R2: logical shifts at 1 and width-1
        step(3'd1, 1'b1, 64'h8000_0000_0000_0000, HI, 1'b0, 64'd0, 20'd63, "R2");
        step(3'd1, 1'b0, 64'hFFFF_FFFF_8000_0000, HI, 1'b0, 64'd0, 20'd31, "R2 R7");
        step(3'd0, 1'b1, 64'hF000_0000_0000_0001, HI, 1'b0, 64'd0, 20'd1, "R2");
        // R3: overflow boundary
        step(3'd3, 1'b1, 64'h3FFF_FFFF_FFFF_FFFF, HI, 1'b0, 64'd0, 20'd1, "R3 no ovf");
        step(3'd3, 1'b1, 64'h3FFF_FFFF_FFFF_FFFF, HI, 1'b0, 64'd0, 20'd2, "R3 ovf");
        step(3'd3, 1'b1, 64'hC000_0000_0000_0000, HI, 1'b0, 64'd0, 20'd1, "R3 neg");
        step(3'd3, 1'b1, 64'hC000_0000_0000_0000, HI, 1'b0, 64'd0, 20'd2, "R3 neg ovf");
        step(3'd3, 1'b0, 64'h0000_0000_4000_0000, HI, 1'b0, 64'd0, 20'd1, "R3 R7 ovf");
        step(3'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, HI, 1'b0, 64'd0, 20'd31, "R3 R7");
        step(3'd3, 1'b1, 64'h0000_0000_0000_0001, HI, 1'b0, 64'd0, 20'd63, "R3 ovf");
        // R4: zero amount and zero result
        step(3'd3, 1'b1, 64'h8000_0000_0000_0005, HI, 1'b0, 64'd0, 20'd0, "R4 amt0");
        step(3'd3, 1'b0, 64'h0000_0000_8000_0001, HI, 1'b0, 64'd0, 20'd32, "R4 amt=width");
        step(3'd3, 1'b1, 64'd0, HI, 1'b0, 64'd0, 20'd5, "R4 zero");
        // R5: arithmetic right shift
        step(3'd2, 1'b1, 64'h8000_0000_0000_0000, HI, 1'b0, 64'd0, 20'd63, "R5");
        step(3'd2, 1'b0, 64'h1111_1111_8000_0000, HI, 1'b0, 64'd0, 20'd31, "R5 R7");
        step(3'd2, 1'b1, 64'h0000_0000_0000_0006, HI, 1'b0, 64'd0, 20'd1, "R5 pos");
        step(3'd2, 1'b1, 64'd1, HI, 1'b0, 64'd0, 20'd1, "R5 zero");
        // R6: rotate
        step(3'd4, 1'b1, 64'h8000_0000_0000_0001, HI, 1'b0, 64'd0, 20'd1, "R6");
        step(3'd4, 1'b0, 64'hFFFF_0000_8000_0001, HI, 1'b0, 64'd0, 20'd4, "R6 R7");
        step(3'd4, 1'b1, 64'h0123_4567_89AB_CDEF, HI, 1'b0, 64'd0, 20'd63, "R6");
        // R9: reserved codes
        step(3'd5, 1'b1, 64'hFFFF, 64'h1357_9BDF_2468_ACE0, 1'b0, 64'd0, 20'd3, "R9");
        step(3'd7, 1'b0, 64'hFFFF, 64'h0F0F_0F0F_F0F0_F0F0, 1'b1, 64'd9, 20'd3, "R9");
        // Mixed patterns
        for (int i = 0; i < 600; i++) begin
            logic [2:0]  op;
            logic        wd;
            logic [63:0] s;
            op = 3'($urandom % 6);
            if (op == 3'd5) op = 3'($urandom % 8);
            wd = 1'($urandom);
            s  = {$urandom, $urandom};
            if (i % 3 == 0) s = (s[0] ? ~64'd0 : 64'd0) ^ (64'd1 << ($urandom % 64));
            step(op, wd, s, {$urandom, $urandom}, 1'($urandom),
                 {$urandom, $urandom}, 20'($urandom), tag_of(op, wd));
        end
        @(negedge clk);
        compare_head();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(100_000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule